// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits in the fetch stage and is looked up every cycle with the current fetch address. When a valid entry in the selected set carries the same tag, the block reports a hit, returns the short taken/not-taken history kept for that branch, and predicts from the newest outcome in that history. If the prediction is taken, the next fetch address is the stored target. On a miss, or when the prediction is not taken, fetch continues at the next sequential word.

When a branch resolves in execute, a single update port writes the buffer. It passes the branch address, the actual outcome and the actual target. If the branch is already present, its history shifts by one outcome and its target is replaced. If it is absent, an entry is allocated in its set. Invalid ways are filled first. In a full set, the least recently used way is replaced.

Top module: `btb`

## Requirements
- R1: After synchronous reset every way is invalid, so no lookup hits until an update has written the address.
- R2: Addresses are word aligned (bits [1:0] zero). Bits [8:2] select one of 128 sets and bits [31:9] form the tag. A lookup hits in the same cycle only when a valid way of that set holds the same tag. An address that shares only the index or only the tag misses.
- R3: On a miss, or on a hit whose newest history bit is 0, `next_pc` equals `fetch_pc + 4` and `fetch_taken` is 0. On a miss, `fetch_hist` reads 0.
- R4: On a hit whose newest history bit (bit 0, 1 = taken) is 1, `fetch_taken` is 1 and `next_pc` equals the stored target.
- R5: An update that hits shifts the entry's 4-bit history left and places the new outcome in bit 0, dropping the oldest bit (bit 3). It also replaces the stored target. A lookup sees the new contents from the cycle after the update edge.
- R6: An update that misses allocates an entry holding the tag and the target, with history 000 followed by the outcome in bit 0. While a set has an invalid way, allocation never evicts a valid entry.
- R7: In a full set, allocation replaces the least recently used way. A lookup hit with `fetch_en` high, an update hit and an allocation each make that way the most recently used. A lookup with `fetch_en` low leaves the recency order unchanged. When a lookup and an update touch the same set in one cycle, the update's way ends up most recent.
- R8: When a lookup and an update address the same set in one cycle, the lookup returns the contents from before the update.
- R9: `fetch_hist` presents the stored history with the oldest outcome at bit 3 and the newest at bit 0. For example, 0101 means not taken, taken, not taken, taken.
- R10: No set ever holds two valid ways with the same tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Lookup is a real fetch; a hit updates recency |
| fetch_pc | input | 32 | Current fetch address |
| fetch_hit | output | 1 | A valid way matches the fetch address |
| fetch_taken | output | 1 | Prediction taken (hit and newest history bit set) |
| fetch_hist | output | 4 | Stored history of the hit entry, 0 on a miss |
| fetch_target | output | 32 | Stored target of the hit entry, 0 on a miss |
| next_pc | output | 32 | Predicted next fetch address |
| upd_en | input | 1 | Resolved branch update valid |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_target | input | 32 | Actual target address |

## Verification
Lookup results are combinational from registered storage, so they are due in the same cycle the fetch address is applied. The bench drives each address on a falling edge and samples the outputs shortly afterwards, before the next rising edge. An update takes effect at the next rising edge, so its result is looked up from the following falling edge onwards. A recency change caused by a lookup with `fetch_en` high also becomes visible only through the next allocation. For the same-cycle case, the bench samples once before the shared edge, expecting the old contents, and once after it, expecting the new ones.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFS_W    = 2;
    localparam int DEF_SETS = 128;
    localparam int DEF_WAYS = 4;
    localparam int DEF_HIST = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    // Sequential successor of a word-aligned fetch address
    function automatic addr_t seq_next(addr_t pc);
        return pc + addr_t'(1 << OFS_W);
    endfunction

endpackage

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int IDX_W = 7,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       a_en,
    input  logic [IDX_W-1:0]           a_idx,
    input  logic [WAY_W-1:0]           a_way,
    input  logic                       b_en,
    input  logic [IDX_W-1:0]           b_idx,
    input  logic [WAY_W-1:0]           b_way,
    output logic [WAYS-1:0][WAY_W-1:0] b_age
);

    typedef logic [WAYS-1:0][WAY_W-1:0] age_vec_t;

    age_vec_t age_q [SETS];
    age_vec_t a_new, b_base, b_new;
    logic [WAYS-1:0] oldest_vec;

    // Age 0 is most recent; every way younger than the touched one ages by one
    function automatic age_vec_t touch(age_vec_t cur, logic [WAY_W-1:0] sel);
        age_vec_t nxt;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == sel)      nxt[w] = '0;
            else if (cur[w] < cur[sel]) nxt[w] = cur[w] + 1'b1;
            else                        nxt[w] = cur[w];
        end
        return nxt;
    endfunction

    always_comb begin
        a_new  = touch(age_q[a_idx], a_way);
        b_base = (a_en && (a_idx == b_idx)) ? a_new : age_q[b_idx];
        b_new  = touch(b_base, b_way);
    end

    assign b_age = age_q[b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else begin
            if (a_en) age_q[a_idx] <= a_new;
            if (b_en) age_q[b_idx] <= b_new;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++)
            oldest_vec[w] = (b_age[w] == WAY_W'(WAYS-1));
    end

    AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1); // R7

endmodule

// File: rtl/btb.sv
module btb
    import btb_pkg::*;
#(
    parameter int SETS   = DEF_SETS,
    parameter int WAYS   = DEF_WAYS,
    parameter int HIST_W = DEF_HIST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_hit,
    output logic              fetch_taken,
    output logic [HIST_W-1:0] fetch_hist,
    output logic [ADDR_W-1:0] fetch_target,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [HIST_W-1:0] hist;
        addr_t             target;
    } entry_t;

    entry_t mem_q [SETS][WAYS];

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic [WAYS-1:0]            f_valid, u_valid, f_hit_vec, u_hit_vec;
    logic [WAYS-1:0][TAG_W-1:0] f_tags, u_tags;
    logic             f_hit, u_hit;
    logic [WAY_W-1:0] f_way, u_way, vic_way, wr_way;
    logic [WAYS-1:0][WAY_W-1:0] u_age;
    entry_t           f_ent, u_old;
    logic [HIST_W-1:0] u_shifted;

    assign f_idx = fetch_pc[OFS_W +: IDX_W];
    assign f_tag = fetch_pc[ADDR_W-1 -: TAG_W];
    assign u_idx = upd_pc[OFS_W +: IDX_W];
    assign u_tag = upd_pc[ADDR_W-1 -: TAG_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            f_valid[w] = mem_q[f_idx][w].valid;
            f_tags[w]  = mem_q[f_idx][w].tag;
            u_valid[w] = mem_q[u_idx][w].valid;
            u_tags[w]  = mem_q[u_idx][w].tag;
        end
    end

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fmatch (
        .valid(f_valid), .tags(f_tags), .key(f_tag),
        .hit_vec(f_hit_vec), .hit(f_hit), .way(f_way)
    );

    btb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_umatch (
        .valid(u_valid), .tags(u_tags), .key(u_tag),
        .hit_vec(u_hit_vec), .hit(u_hit), .way(u_way)
    );

    // Lookup path: reads registered contents, so same-cycle updates are not seen
    assign f_ent        = mem_q[f_idx][f_way];
    assign fetch_hit    = f_hit;
    assign fetch_hist   = f_hit ? f_ent.hist : '0;
    assign fetch_target = f_hit ? f_ent.target : '0;
    assign fetch_taken  = f_hit && f_ent.hist[0];
    assign next_pc      = fetch_taken ? f_ent.target : seq_next(fetch_pc);

    // Victim: lowest invalid way, else the oldest way of the set
    always_comb begin
        logic found;
        found   = 1'b0;
        vic_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !u_valid[w]) begin
                vic_way = WAY_W'(w);
                found   = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++)
                if (u_age[w] == WAY_W'(WAYS-1)) vic_way = WAY_W'(w);
        end
    end

    assign wr_way    = u_hit ? u_way : vic_way;
    assign u_old     = mem_q[u_idx][u_way];
    assign u_shifted = {u_old.hist[HIST_W-2:0], upd_taken};

    btb_lru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_lru (
        .clk(clk), .rst(rst),
        .a_en(fetch_en && f_hit), .a_idx(f_idx), .a_way(f_way),
        .b_en(upd_en), .b_idx(u_idx), .b_way(wr_way),
        .b_age(u_age)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    mem_q[s][w].valid <= 1'b0;
        end else if (upd_en) begin
            if (u_hit) begin
                mem_q[u_idx][u_way].hist   <= u_shifted;
                mem_q[u_idx][u_way].target <= upd_target;
            end else begin
                mem_q[u_idx][vic_way].valid  <= 1'b1;
                mem_q[u_idx][vic_way].tag    <= u_tag;
                mem_q[u_idx][vic_way].hist   <= HIST_W'(upd_taken);
                mem_q[u_idx][vic_way].target <= upd_target;
            end
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fetch_hit); // R1

    AST_UPD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> (upd_pc[OFS_W-1:0] == '0)); // R2

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(f_hit_vec) && $onehot0(u_hit_vec)); // R10

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (upd_en && u_hit) |=>
        (mem_q[$past(u_idx)][$past(wr_way)].hist == $past(u_shifted))); // R5

    AST_ALLOC_FILL: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !u_hit) |=>
        (mem_q[$past(u_idx)][$past(wr_way)].valid &&
         mem_q[$past(u_idx)][$past(wr_way)].tag == $past(u_tag) &&
         mem_q[$past(u_idx)][$past(wr_way)].hist == HIST_W'($past(upd_taken)))); // R6

endmodule

// File: tb/btb_bench.sv
module btb_bench;
    import btb_pkg::*;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_en = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_hit, fetch_taken;
    logic [3:0]  fetch_hist;
    logic [31:0] fetch_target, next_pc;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb u_btb (
        .clk(clk), .rst(rst), .fetch_en(fetch_en), .fetch_pc(fetch_pc),
        .fetch_hit(fetch_hit), .fetch_taken(fetch_taken), .fetch_hist(fetch_hist),
        .fetch_target(fetch_target), .next_pc(next_pc),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    function automatic logic [31:0] mk(int tag, int idx);
        return {tag[22:0], idx[6:0], 2'b00};
    endfunction

    // Compare lookup outputs against values derived from the requirements
    task automatic expect_now(string req, logic [31:0] pc, bit e_hit,
                              logic [3:0] e_hist, logic [31:0] tgt);
        bit          e_taken;
        logic [3:0]  eh;
        logic [31:0] e_next;
        e_taken = e_hit && e_hist[0];
        eh      = e_hit ? e_hist : 4'b0000;
        e_next  = e_taken ? tgt : pc + 32'd4;
        checks++;
        if (fetch_hit !== e_hit || fetch_taken !== e_taken ||
            fetch_hist !== eh || next_pc !== e_next) begin
            errors++;
            $display("FAIL %s pc=%h actual hit=%b taken=%b hist=%b next=%h expected hit=%b taken=%b hist=%b next=%h",
                     req, pc, fetch_hit, fetch_taken, fetch_hist, next_pc,
                     e_hit, e_taken, eh, e_next);
        end
    endtask

    task automatic look(string req, logic [31:0] pc, bit en, bit e_hit,
                        logic [3:0] e_hist, logic [31:0] tgt);
        @(negedge clk);
        upd_en   = 1'b0;
        fetch_pc = pc;
        fetch_en = en;
        #1;
        expect_now(req, pc, e_hit, e_hist, tgt);
    endtask

    task automatic upd(logic [31:0] pc, bit taken, logic [31:0] tgt);
        @(negedge clk);
        fetch_en   = 1'b0;
        upd_en     = 1'b1;
        upd_pc     = pc;
        upd_taken  = taken;
        upd_target = tgt;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic t_reset;
        look("R1", mk(1, 3), 1'b1, 1'b0, 4'b0000, '0);
        look("R1_R3", mk(0, 0), 1'b0, 1'b0, 4'b0000, '0);
        look("R3", mk(5, 127), 1'b1, 1'b0, 4'b0000, '0);
    endtask

    task automatic t_history;
        logic [31:0] a;
        a = mk(1, 3);
        upd(a, 1'b1, 32'h0000_4000);
        look("R4_R6", a, 1'b0, 1'b1, 4'b0001, 32'h0000_4000);
        upd(a, 1'b0, 32'h0000_4000);
        look("R3_R5", a, 1'b0, 1'b1, 4'b0010, 32'h0000_4000);
        upd(a, 1'b1, 32'h0000_8800);
        look("R5_R9", a, 1'b0, 1'b1, 4'b0101, 32'h0000_8800);
        upd(a, 1'b0, 32'h0000_8800);
        upd(a, 1'b1, 32'h0000_8800);
        upd(a, 1'b1, 32'h0000_8800);
        upd(a, 1'b1, 32'h0000_8800);
        look("R5", a, 1'b0, 1'b1, 4'b0111, 32'h0000_8800);
        upd(a, 1'b1, 32'h0000_8800);
        look("R5_R9", a, 1'b0, 1'b1, 4'b1111, 32'h0000_8800);
        upd(mk(3, 3), 1'b0, 32'h0000_1234);
        look("R6_R3", mk(3, 3), 1'b0, 1'b1, 4'b0000, 32'h0000_1234);
    endtask

    task automatic t_alias;
        look("R2", mk(2, 3), 1'b0, 1'b0, 4'b0000, '0);
        look("R2", mk(1, 4), 1'b0, 1'b0, 4'b0000, '0);
        look("R2", mk(1, 3), 1'b0, 1'b1, 4'b1111, 32'h0000_8800);
    endtask

    task automatic t_lru_update_touch;
        for (int k = 0; k < 4; k++) upd(mk(16 + k, 9), 1'b1, 32'h100 + 32'(k) * 32'h40);
        for (int k = 0; k < 4; k++)
            look("R6", mk(16 + k, 9), 1'b0, 1'b1, 4'b0001, 32'h100 + 32'(k) * 32'h40);
        upd(mk(16, 9), 1'b1, 32'h100);                  // update hit makes way of tag 16 newest
        look("R7", mk(17, 9), 1'b0, 1'b1, 4'b0001, 32'h140); // no touch
        upd(mk(20, 9), 1'b1, 32'h200);                  // evicts tag 17
        look("R7", mk(17, 9), 1'b0, 1'b0, 4'b0000, '0);
        look("R7", mk(16, 9), 1'b0, 1'b1, 4'b0011, 32'h100);
        look("R7", mk(18, 9), 1'b0, 1'b1, 4'b0001, 32'h180); // en low keeps 18 oldest
        upd(mk(21, 9), 1'b1, 32'h240);                  // evicts tag 18
        look("R7", mk(18, 9), 1'b0, 1'b0, 4'b0000, '0);
        look("R7", mk(19, 9), 1'b0, 1'b1, 4'b0001, 32'h1c0);
        look("R7", mk(21, 9), 1'b0, 1'b1, 4'b0001, 32'h240);
    endtask

    task automatic t_lru_fetch_touch;
        for (int k = 0; k < 4; k++) upd(mk(40 + k, 20), 1'b1, 32'h900 + 32'(k) * 32'h10);
        look("R7", mk(40, 20), 1'b1, 1'b1, 4'b0001, 32'h900); // fetch hit touches
        upd(mk(44, 20), 1'b0, 32'h990);                 // evicts tag 41
        look("R7", mk(41, 20), 1'b0, 1'b0, 4'b0000, '0);
        look("R7", mk(40, 20), 1'b0, 1'b1, 4'b0001, 32'h900);
        look("R7", mk(44, 20), 1'b0, 1'b1, 4'b0000, 32'h990);
    endtask

    task automatic t_same_cycle;
        logic [31:0] b;
        b = mk(7, 50);
        upd(b, 1'b1, 32'h0000_7000);
        @(negedge clk);
        fetch_pc   = b;
        fetch_en   = 1'b1;
        upd_en     = 1'b1;
        upd_pc     = b;
        upd_taken  = 1'b0;
        upd_target = 32'h0000_7000;
        #1;
        expect_now("R8", b, 1'b1, 4'b0001, 32'h0000_7000);
        @(negedge clk);
        upd_en   = 1'b0;
        fetch_en = 1'b0;
        #1;
        expect_now("R8_R5", b, 1'b1, 4'b0010, 32'h0000_7000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_history();
        t_alias();
        t_lru_update_touch();
        t_lru_fetch_touch();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog requirement=all actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule